// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a virtual address into a physical page after a translation cache miss. A walk begins with a one-cycle start pulse that carries a 48-bit virtual address and the page number of the root table. The walker then reads one 8-byte entry from each of four table levels, one level after another, through a simple request/response memory port. Each level is indexed by a 9-bit slice of the virtual address.

A walk ends in one of two ways. If the final entry is valid, the walker delivers the physical page number, the full physical address and a non-global flag to the translation cache on a one-cycle fill pulse. If an entry at any level is marked invalid, the walker ends the walk with a one-cycle fault pulse that reports which level failed. Only one walk is handled at a time, and `busy` marks the time a walk is in progress.

Top module: `pt_walker`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `busy`, `mem_req_valid`, `fill_valid` and `fault_valid` are all 0.
- R2: A `start` pulse seen while idle captures `start_vaddr` and `root_ppn`, and `busy` is 1 from the next cycle. The first request address is `{root_ppn, 12'b0} + start_vaddr[47:39]*8`.
- R3: Levels are read in the order 0, 1, 2, 3, using the index slices [47:39], [38:30], [29:21] and [20:12]. Each entry address is the table base times 4096 plus index×8. The next table base is bits [47:12] of the previous entry, whose bit 0 is its valid flag.
- R4: Each level produces exactly one memory request. A successful walk issues exactly four requests, and no request is issued while a response is pending or after the walk has ended.
- R5: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted and `mem_req_addr` stays unchanged.
- R6: A valid leaf entry raises `fill_valid` for exactly one cycle, in the cycle after its response. In that cycle `fill_ppn` equals leaf bits [47:12], `fill_vpn` equals vaddr[47:12], and `fill_paddr` equals `{fill_ppn, vaddr[11:0]}`.
- R7: `fill_nonglobal` equals bit 11 of the leaf entry.
- R8: An entry with bit 0 clear at level k raises `fault_valid` for one cycle, with `fault_level` equal to k. That walk produces no fill and issues no further request.
- R9: `busy` is 0 in the cycle that a fill or fault pulse appears, and the walker then accepts a new `start`.
- R10: A `start` pulse during a walk is ignored. The walk continues with its original address and root.
- R11: A `mem_resp_valid` pulse while no response is pending has no effect. It causes no fill, no fault and no change to `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (used only when idle) |
| start_vaddr | input | 48 | Virtual address to translate |
| root_ppn | input | 36 | Page number of the top-level table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 48 | Byte address of the entry to read |
| mem_resp_valid | input | 1 | Read data is valid |
| mem_resp_data | input | 64 | Table entry read from memory |
| fill_valid | output | 1 | One-cycle pulse: translation ready for the cache |
| fill_vpn | output | 36 | Virtual page number of the translation |
| fill_ppn | output | 36 | Physical page number from the leaf entry |
| fill_paddr | output | 48 | Full translated physical address |
| fill_nonglobal | output | 1 | Non-global flag from the leaf entry |
| fault_valid | output | 1 | One-cycle pulse: walk ended on an invalid entry |
| fault_level | output | 2 | Level whose entry was invalid |

## Verification
The bench checks request stalls of random length and confirms that the address holds. A walker that dropped or changed the request under stall would read the wrong entry. It forces invalid entries at every level, including the leaf, so that an off-by-one in the level counter would show up as a wrong `fault_level`, a stray fill or an extra request. It also injects a new `start` mid-walk and an unsolicited response while idle. A walker that accepted either would change its addresses or emit a phantom result. Finally, it uses all-ones and all-zero addresses, which expose wrong slice positions and carry errors in the index-times-8 addition.

// File: rtl/ptw_pkg.sv
// Package: shared constants and state type for the page table walker.
// Assumes 64-bit entries with the valid flag at bit 0 and the non-global flag at bit 11.
package ptw_pkg;
    localparam int ENTRY_W   = 64;
    localparam int VALID_BIT = 0;
    localparam int NG_BIT    = 11;
    localparam int ENTRY_SH  = 3;   // log2 of entry size in bytes

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } walk_state_e;
endpackage

// File: rtl/ptw_index_sel.sv
// Index selector: picks the virtual address slice that indexes the table of the current level.
// Assumes level 0 uses the topmost IDX_W bits and each later level the next lower slice.
module ptw_index_sel #(
    parameter int VA_W   = 48,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic [IDX_W-1:0] index
);
    logic [IDX_W-1:0] slice [LEVELS];

    // One slice per level, taken from the top of the address downwards.
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = vaddr[VA_W-1-g*IDX_W -: IDX_W];
    end

    // Choose the slice of the active level.
    assign index = slice[level];
endmodule

// File: rtl/ptw_addr_gen.sv
// Entry address generator: table base page shifted to a byte address plus index times entry size.
// Assumes the table base is page aligned.
module ptw_addr_gen #(
    parameter int PA_W     = 48,
    parameter int PG_SH    = 12,
    parameter int IDX_W    = 9,
    localparam int PPN_W   = PA_W - PG_SH
) (
    input  logic [PPN_W-1:0] base_ppn,
    input  logic [IDX_W-1:0] index,
    output logic [PA_W-1:0]  entry_addr
);
    logic [PA_W-1:0] base_byte;
    logic [PA_W-1:0] offset;

    // Byte address of the table and byte offset of the entry.
    assign base_byte  = {base_ppn, {PG_SH{1'b0}}};
    assign offset     = PA_W'({index, {ptw_pkg::ENTRY_SH{1'b0}}});
    assign entry_addr = base_byte + offset;
endmodule

// File: rtl/ptw_ctrl.sv
// Walk controller: sequences the level reads and registers the fill or fault result.
// Assumes one walk at a time; responses arrive only after an accepted request.
module ptw_ctrl
    import ptw_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int PA_W   = 48,
    parameter int PG_SH  = 12,
    parameter int LEVELS = 4,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int PPN_W = PA_W - PG_SH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VA_W-1:0]    start_vaddr,
    input  logic [PPN_W-1:0]   root_ppn,
    input  logic               mem_req_ready,
    input  logic               mem_resp_valid,
    input  logic [ENTRY_W-1:0] mem_resp_data,
    output logic               busy,
    output logic               mem_req_valid,
    output logic [VA_W-1:0]    va_q,
    output logic [LVL_W-1:0]   lvl_q,
    output logic [PPN_W-1:0]   base_q,
    output logic               fill_valid,
    output logic [PPN_W-1:0]   fill_ppn,
    output logic               fill_ng,
    output logic               fault_valid,
    output logic [LVL_W-1:0]   fault_lvl
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_e      state;
    logic             entry_ok;
    logic [PPN_W-1:0] entry_ppn;

    // Decode the fields of the returned entry.
    assign entry_ok  = mem_resp_data[VALID_BIT];
    assign entry_ppn = mem_resp_data[PG_SH +: PPN_W];

    // Outputs that follow the state directly.
    assign busy          = (state != ST_IDLE);
    assign mem_req_valid = (state == ST_REQ);

    // Walk sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            va_q        <= '0;
            lvl_q       <= '0;
            base_q      <= '0;
            fill_valid  <= 1'b0;
            fill_ppn    <= '0;
            fill_ng     <= 1'b0;
            fault_valid <= 1'b0;
            fault_lvl   <= '0;
        end else begin
            fill_valid  <= 1'b0;
            fault_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        va_q   <= start_vaddr;
                        base_q <= root_ppn;
                        lvl_q  <= '0;
                        state  <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_resp_valid) begin
                        if (!entry_ok) begin
                            fault_valid <= 1'b1;
                            fault_lvl   <= lvl_q;
                            state       <= ST_IDLE;
                        end else if (lvl_q == LAST_LVL) begin
                            fill_valid <= 1'b1;
                            fill_ppn   <= entry_ppn;
                            fill_ng    <= mem_resp_data[NG_BIT];
                            state      <= ST_IDLE;
                        end else begin
                            base_q <= entry_ppn;
                            lvl_q  <= lvl_q + 1'b1;
                            state  <= ST_REQ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: a stalled request stays asserted.
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

    // R6: the fill is a single-cycle pulse.
    p_fill_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);

    // R8: a fault never coincides with a fill and is a single-cycle pulse.
    p_fault_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> !fill_valid);
    p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid);

    // R9: a result is reported only once the walker is idle again.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid || fault_valid) |-> !busy);

    // R3: moving on to the next request advances the level by exactly one.
    p_lvl_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !$past(mem_req_valid) && $past(busy)) |-> (lvl_q == $past(lvl_q) + 1'b1));

    // R10: the captured address is frozen while a walk runs.
    p_va_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(va_q));
endmodule

// File: rtl/pt_walker.sv
// Page table walker top: joins the controller, index selector and address generator.
// Assumes a single outstanding memory read; the result stays on the fill outputs until the next walk.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int PA_W   = 48,
    parameter int PG_SH  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int PPN_W = PA_W - PG_SH,
    localparam int VPN_W = VA_W - PG_SH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VA_W-1:0]    start_vaddr,
    input  logic [PPN_W-1:0]   root_ppn,
    output logic               busy,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_resp_valid,
    input  logic [ENTRY_W-1:0] mem_resp_data,
    output logic               fill_valid,
    output logic [VPN_W-1:0]   fill_vpn,
    output logic [PPN_W-1:0]   fill_ppn,
    output logic [PA_W-1:0]    fill_paddr,
    output logic               fill_nonglobal,
    output logic               fault_valid,
    output logic [LVL_W-1:0]   fault_level
);
    logic [VA_W-1:0]  va_q;
    logic [LVL_W-1:0] lvl_q;
    logic [PPN_W-1:0] base_q;
    logic [IDX_W-1:0] index;

    ptw_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .PG_SH(PG_SH), .LEVELS(LEVELS)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .start_vaddr    (start_vaddr),
        .root_ppn       (root_ppn),
        .mem_req_ready  (mem_req_ready),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data),
        .busy           (busy),
        .mem_req_valid  (mem_req_valid),
        .va_q           (va_q),
        .lvl_q          (lvl_q),
        .base_q         (base_q),
        .fill_valid     (fill_valid),
        .fill_ppn       (fill_ppn),
        .fill_ng        (fill_nonglobal),
        .fault_valid    (fault_valid),
        .fault_lvl      (fault_level)
    );

    ptw_index_sel #(.VA_W(VA_W), .IDX_W(IDX_W), .LEVELS(LEVELS)) u_idx (
        .vaddr (va_q),
        .level (lvl_q),
        .index (index)
    );

    ptw_addr_gen #(.PA_W(PA_W), .PG_SH(PG_SH), .IDX_W(IDX_W)) u_addr (
        .base_ppn   (base_q),
        .index      (index),
        .entry_addr (mem_req_addr)
    );

    // Translation fields handed to the cache.
    assign fill_vpn   = va_q[VA_W-1:PG_SH];
    assign fill_paddr = {fill_ppn, va_q[PG_SH-1:0]};

    // R1: nothing is active in the first cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !mem_req_valid && !fill_valid && !fault_valid));
endmodule

// File: tb/pt_walker_tb.sv
// Bench: hashed page-table memory model, random and directed walks, and a software reference walk.
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] start_vaddr = '0;
    logic [35:0] root_ppn = '0;
    logic        busy, mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [47:0] mem_req_addr;
    logic        mem_resp_valid = 1'b0;
    logic [63:0] mem_resp_data = '0;
    logic        fill_valid, fill_nonglobal, fault_valid;
    logic [35:0] fill_vpn, fill_ppn;
    logic [47:0] fill_paddr;
    logic [1:0]  fault_level;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_vaddr(start_vaddr),
        .root_ppn(root_ppn), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_paddr(fill_paddr), .fill_nonglobal(fill_nonglobal),
        .fault_valid(fault_valid), .fault_level(fault_level)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Watchdog: a hung run is a failure that still reaches the summary.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fail++;
                $display("FAIL watchdog (R4) act=%0d cycles exp<=150000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Memory model: entry content is a hash of its address.
    function automatic logic [63:0] ent(input logic [47:0] a);
        logic [63:0] h;
        logic [63:0] e;
        h = {16'h0, a} * 64'h9E3779B97F4A7C15;
        h = h ^ (h >> 29) ^ 64'h5bd1e995_1234abcd;
        e = h;                       // reserved bits carry noise
        e[0] = (h[22:18] != 5'd0);   // about 1 in 32 entries invalid
        return e;
    endfunction

    // Reference entry address for a level.
    function automatic logic [47:0] ref_addr(input logic [35:0] base, input logic [47:0] va, input int l);
        logic [8:0] idx;
        idx = va[47-9*l -: 9];
        return {base, 12'b0} + {36'b0, idx, 3'b0};
    endfunction

    // One walk with reference checking; force_lvl<4 clears the valid bit at that level.
    task automatic run_walk(input logic [47:0] va, input logic [35:0] root, input int force_lvl, input bit poke);
        logic [35:0] base;
        logic [63:0] e;
        logic [47:0] a_exp;
        bit          done;
        int          guard;
        base = root;
        done = 0;
        @(negedge clk);
        start = 1'b1; start_vaddr = va; root_ppn = root;
        @(negedge clk);
        start = 1'b0; start_vaddr = ~va; root_ppn = ~root;
        chk("R2 busy after start", {63'b0, busy}, 64'd1);
        for (int l = 0; l < 4 && !done; l++) begin
            a_exp = ref_addr(base, va, l);
            guard = 0;
            while (!mem_req_valid && guard < 20) begin
                @(negedge clk); guard++;
            end
            chk(l == 0 ? "R2 first addr" : "R3 level addr", {16'b0, mem_req_addr}, {16'b0, a_exp});
            for (int s = 0; s < int'($urandom % 3); s++) begin
                if (poke && l == 1) begin start = 1'b1; start_vaddr = ~va; end
                @(negedge clk);
                start = 1'b0;
                chk("R5 stall hold", {15'b0, mem_req_valid, mem_req_addr}, {15'b0, 1'b1, a_exp});
            end
            if (poke && l == 1) start = 1'b1;
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0; start = 1'b0;
            for (int d = 0; d < int'($urandom % 3); d++) begin
                chk("R4 no request while pending", {63'b0, mem_req_valid}, 64'd0);
                @(negedge clk);
            end
            e = ent(a_exp);
            if (l == force_lvl) e[0] = 1'b0;
            mem_resp_valid = 1'b1; mem_resp_data = e;
            @(negedge clk);
            mem_resp_valid = 1'b0; mem_resp_data = $urandom;
            if (!e[0]) begin
                chk("R8 fault pulse", {63'b0, fault_valid}, 64'd1);
                chk("R8 fault level", {62'b0, fault_level}, l);
                chk("R8 no fill", {63'b0, fill_valid}, 64'd0);
                chk("R9 idle at fault", {63'b0, busy}, 64'd0);
                done = 1;
            end else if (l == 3) begin
                chk("R6 fill pulse", {63'b0, fill_valid}, 64'd1);
                chk("R6 fill ppn", {28'b0, fill_ppn}, {28'b0, e[47:12]});
                chk("R6 fill vpn (R10)", {28'b0, fill_vpn}, {28'b0, va[47:12]});
                chk("R6 fill paddr", {16'b0, fill_paddr}, {16'b0, e[47:12], va[11:0]});
                chk("R7 nonglobal", {63'b0, fill_nonglobal}, {63'b0, e[11]});
                chk("R9 idle at fill", {63'b0, busy}, 64'd0);
                done = 1;
            end else begin
                base = e[47:12];
            end
        end
        @(negedge clk);
        chk("R4 no request after end", {61'b0, mem_req_valid, fill_valid, fault_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset quiet", {60'b0, busy, mem_req_valid, fill_valid, fault_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {60'b0, busy, mem_req_valid, fill_valid, fault_valid}, 64'd0);

        // R11: unsolicited response while idle.
        mem_resp_valid = 1'b1; mem_resp_data = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        mem_resp_valid = 1'b0;
        @(negedge clk);
        chk("R11 stray response ignored", {61'b0, busy, fill_valid, fault_valid}, 64'd0);

        // Directed corners.
        run_walk(48'hFFFF_FFFF_FFFF, 36'hF_FFFF_FFFF, 4, 0);
        run_walk(48'h0, 36'h0, 4, 0);
        for (int k = 0; k < 4; k++) run_walk(48'h8040_2010_0ABC + 48'(k), 36'h1_2345_6789, k, 0);
        run_walk(48'h7FC0_3FE0_1FF5, 36'hA_5A5A_5A5A, 4, 1);  // R10 start during walk

        // Random walks with a fixed seed.
        void'($urandom(32'd2024));
        for (int i = 0; i < 60; i++) begin
            run_walk({$urandom, $urandom} & 48'hFFFF_FFFF_FFFF, {$urandom, $urandom} & 36'hF_FFFF_FFFF,
                     ($urandom % 4 == 0) ? int'($urandom % 4) : 4, ($urandom % 5 == 0));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule